// File: doc/BRIEF.md
# Dual-Edge Pixel Bus Demultiplexer

This block sits at the front of a video pipeline. It takes a narrow pixel bus that carries a new word on both the rising and the falling edge of the pixel clock, and it rebuilds full 24-bit pixels from those words. One register captures the bus on the falling edge. The rest of the logic runs on the rising edge, where the two half-words are paired, unscrambled into 8-bit red/green/blue (or Cr/Y/Cb) components, and presented one pixel per clock with a valid strobe.

Four bus layouts are supported. The first is 24-bit colour on twelve pins. The next two are 15-bit and 16-bit RGB on eight pins. The last is 8-bit 4:2:2 luma/chroma, where two pixels are spread over four consecutive edges. For the three RGB layouts, two control bits choose which clock edge opens a pixel and which half-word comes first. A synchronous align input restarts the pixel and pair framing. A change of layout suppresses the strobe until the new framing has filled.

Top module: `dvin_demux`

## Requirements
- R1: While `rst_n` is low, and after reset until the first pixel is framed, `valid_o` is 0 and `pix_o` is 0.
- R2: With `fmt`=0 and `half_order`=0, the first half-word holds G[3:0] on `din[11:8]` and B[7:0] on `din[7:0]`. The second half-word holds R[7:0] on `din[11:4]` and G[7:4] on `din[3:0]`. `pix_o` is {R,G,B}, with R in bits 23:16, G in 15:8 and B in 7:0.
- R3: With `half_order`=1, the half-word carrying red arrives first and the half-word carrying low green and blue arrives second. The assembled pixel is the same as with `half_order`=0.
- R4: When `first_edge`=0, a pixel pairs the word taken at a rising edge with the word taken at the next falling edge. When `first_edge`=1, it pairs the word taken at a falling edge with the word taken at the next rising edge. The result appears after the rising edge that follows the second word.
- R5: With `fmt`=1 (RGB 5-5-5), the low half holds G[2:0] on `din[7:5]` and B[4:0] on `din[4:0]`. The other half holds R[4:0] on `din[6:2]` and G[4:3] on `din[1:0]`. Pin 7 of that half and pins 11:8 of both halves are ignored. Each 5-bit value v is widened to {v, v[4:2]}.
- R6: With `fmt`=2 (RGB 5-6-5), the low half is laid out as in R5. The other half holds R[4:0] on `din[7:3]` and G[5:3] on `din[2:0]`. A 6-bit green g is widened to {g, g[5:4]}. Pins 11:8 are ignored.
- R7: With `fmt`=3, each clock takes chroma on the falling edge and luma on the following rising edge, using `din[7:0]` only. `half_order` and `first_edge` are ignored. Bytes arrive in the order Cb, Y0, Cr, Y1. The block outputs {Cr,Y0,Cb} and then {Cr,Y1,Cb}, so both pixels of a pair carry the same chroma.
- R8: `align` high at a rising edge drops `valid_o` after that edge. In 4:2:2 mode, the falling-edge byte of the next clock is then taken as Cb.
- R9: A change of `fmt` between two rising edges drops `valid_o` after the second edge and restarts framing.
- R10: After a restart (reset, `align` or a change of format), `valid_o` first rises after the second rising edge. It then stays high every clock for as long as no restart occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges carry data |
| rst_n | input | 1 | Synchronous reset, active low |
| align | input | 1 | Synchronous framing restart |
| fmt | input | 2 | Bus layout: 0 = 24-bit, 1 = 5-5-5, 2 = 5-6-5, 3 = 4:2:2 |
| half_order | input | 1 | 0: low-green/blue half first; 1: red half first |
| first_edge | input | 1 | 0: pixel opens on rising edge; 1: on falling edge |
| din | input | 12 | Dual-edge pixel data bus |
| pix_o | output | 24 | Assembled pixel {R/Cr, G/Y, B/Cb} |
| valid_o | output | 1 | Pixel strobe, one per clock when framed |

## Verification
The bench sends two different pixels back to back under both edge settings. A design that paired the wrong rising word with a falling word would output a mix of the two pixels. The bench checks the don't-care pins with both values and compares the narrow-colour widening against hand-computed bytes. A design that padded the low bits with zeros would show a wrong low bit pattern. In 4:2:2 mode it fires `align` at a point where the free-running pair phase would be wrong. A design that ignored the realignment would emit a pixel one clock early, with luma taken as chroma.

// File: rtl/dvin_pkg.sv
package dvin_pkg;

    parameter int DV_PD_W = 12;
    parameter int DV_C_W  = 8;
    localparam int DV_PIX_W = 3 * DV_C_W;

    typedef enum logic [1:0] {
        FMT_RGB888 = 2'd0,
        FMT_RGB555 = 2'd1,
        FMT_RGB565 = 2'd2,
        FMT_YC422  = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [1:0]          fmt;
        logic                seen;
        logic                phase;
        logic                pend;
        logic [DV_PD_W-1:0]  rp;
        logic [DV_C_W-1:0]   cb;
        logic [DV_C_W-1:0]   y0;
        logic [DV_PIX_W-1:0] nxt;
        logic [DV_PIX_W-1:0] pix;
        logic                valid;
    } dv_state_t;

    function automatic logic [7:0] widen5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [7:0] widen6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

endpackage

// File: rtl/dvin_fall_cap.sv
module dvin_fall_cap #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d;

    always_comb begin
        q_d = rst_n ? d : '0;
    end

    always_ff @(negedge clk) begin
        q <= q_d;
    end
endmodule

// File: rtl/dvin_unpack.sv
module dvin_unpack
    import dvin_pkg::*;
#(
    parameter int PD_W = DV_PD_W,
    parameter int C_W  = DV_C_W
) (
    input  logic [1:0]       fmt,
    input  logic             half_order,
    input  logic [PD_W-1:0]  first_w,
    input  logic [PD_W-1:0]  second_w,
    output logic [3*C_W-1:0] pix
);
    logic [PD_W-1:0] lo_w;
    logic [PD_W-1:0] hi_w;

    always_comb begin
        lo_w = half_order ? second_w : first_w;
        hi_w = half_order ? first_w  : second_w;
        unique case (fmt)
            FMT_RGB888: pix = {hi_w[11:4], hi_w[3:0], lo_w[11:8], lo_w[7:0]};
            FMT_RGB555: pix = {widen5(hi_w[6:2]),
                               widen5({hi_w[1:0], lo_w[7:5]}),
                               widen5(lo_w[4:0])};
            FMT_RGB565: pix = {widen5(hi_w[7:3]),
                               widen6({hi_w[2:0], lo_w[7:5]}),
                               widen5(lo_w[4:0])};
            default:    pix = '0;
        endcase
    end
endmodule

// File: rtl/dvin_demux.sv
module dvin_demux
    import dvin_pkg::*;
#(
    parameter int PD_W = DV_PD_W,
    parameter int C_W  = DV_C_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              align,
    input  logic [1:0]        fmt,
    input  logic              half_order,
    input  logic              first_edge,
    input  logic [PD_W-1:0]   din,
    output logic [3*C_W-1:0]  pix_o,
    output logic              valid_o
);
    localparam int PIX_W = 3 * C_W;

    dv_state_t        st_d;
    dv_state_t        st_q;
    logic [PD_W-1:0]  fall_q;
    logic [PD_W-1:0]  first_w;
    logic [PD_W-1:0]  second_w;
    logic [PIX_W-1:0] rgb_pix;
    logic             restart;

    dvin_fall_cap #(.W(PD_W)) u_fcap (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (din),
        .q     (fall_q)
    );

    always_comb begin
        first_w  = first_edge ? fall_q : st_q.rp;
        second_w = first_edge ? din    : fall_q;
    end

    dvin_unpack #(.PD_W(PD_W), .C_W(C_W)) u_unp (
        .fmt        (st_q.fmt),
        .half_order (half_order),
        .first_w    (first_w),
        .second_w   (second_w),
        .pix        (rgb_pix)
    );

    always_comb begin
        st_d     = st_q;
        st_d.fmt = fmt;
        st_d.rp  = din;
        restart  = align || (fmt != st_q.fmt);
        if (restart) begin
            st_d.seen  = 1'b0;
            st_d.phase = 1'b0;
            st_d.pend  = 1'b0;
            st_d.valid = 1'b0;
        end else if (st_q.fmt == FMT_YC422) begin
            if (!st_q.phase) begin
                st_d.cb    = fall_q[C_W-1:0];
                st_d.y0    = din[C_W-1:0];
                st_d.valid = st_q.pend;
                st_d.pix   = st_q.nxt;
                st_d.pend  = 1'b0;
                st_d.phase = 1'b1;
            end else begin
                st_d.valid = 1'b1;
                st_d.pix   = {fall_q[C_W-1:0], st_q.y0, st_q.cb};
                st_d.nxt   = {fall_q[C_W-1:0], din[C_W-1:0], st_q.cb};
                st_d.pend  = 1'b1;
                st_d.phase = 1'b0;
            end
        end else begin
            st_d.valid = st_q.seen;
            st_d.pix   = rgb_pix;
            st_d.seen  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.fmt <= fmt;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_o   = st_q.pix;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/dvin_demux_chk.sv
module dvin_demux_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        align,
    input logic [1:0]  fmt,
    input logic [23:0] pix_o,
    input logic        valid_o,
    input logic [1:0]  fmt_q,
    input logic        phase_q
);
    p_align_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        align |=> !valid_o);

    p_fmt_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt != $past(fmt)) |=> !valid_o);

    p_stream_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !align && fmt == $past(fmt)) |=> valid_o);

    p_chroma_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && fmt_q == 2'd3 && phase_q) |->
            (pix_o[23:16] == $past(pix_o[23:16]) && pix_o[7:0] == $past(pix_o[7:0])));
endmodule

bind dvin_demux dvin_demux_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .align   (align),
    .fmt     (fmt),
    .pix_o   (pix_o),
    .valid_o (valid_o),
    .fmt_q   (st_q.fmt),
    .phase_q (st_q.phase)
);

// File: tb/dvin_demux_tb.sv
module dvin_demux_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        align = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic        half_order = 1'b0;
    logic        first_edge = 1'b0;
    logic [11:0] din = '0;
    logic [23:0] pix_o;
    logic        valid_o;
    int          errs = 0;
    int          checks = 0;

    always #10 clk = ~clk;

    dvin_demux u_dut (
        .clk(clk), .rst_n(rst_n), .align(align), .fmt(fmt),
        .half_order(half_order), .first_edge(first_edge),
        .din(din), .pix_o(pix_o), .valid_o(valid_o)
    );

    // {fmt, half_order, first_edge, low half, red half, expected pixel}
    localparam logic [51:0] VEC [8] = '{
        {2'd0, 1'b0, 1'b0, 12'hA5C, 12'h3E7, 24'h3E7A5C},
        {2'd0, 1'b0, 1'b1, 12'hA5C, 12'h3E7, 24'h3E7A5C},
        {2'd0, 1'b1, 1'b0, 12'hA5C, 12'h3E7, 24'h3E7A5C},
        {2'd0, 1'b1, 1'b1, 12'hA5C, 12'h3E7, 24'h3E7A5C},
        {2'd1, 1'b0, 1'b1, 12'h5B3, 12'hAE9, 24'hD66B9C},
        {2'd1, 1'b1, 1'b0, 12'h0B3, 12'h069, 24'hD66B9C},
        {2'd2, 1'b1, 1'b0, 12'hF4A, 12'h0B3, 24'hB56952},
        {2'd2, 1'b0, 1'b1, 12'h04A, 12'h7B3, 24'hB56952}
    };

    // Drives f at the falling edge and r at the next rising edge, then
    // waits until just after that rising edge.
    task automatic step(input logic [11:0] f, input logic [11:0] r, input logic s);
        din = f;
        @(negedge clk);
        #2 din = r;
        align = s;
        @(posedge clk);
        #2 align = 1'b0;
    endtask

    task automatic chk(input string tag, input logic ev, input logic [23:0] ep, input bit use_pix);
        checks++;
        if (valid_o !== ev || (use_pix && pix_o !== ep)) begin
            errs++;
            $display("FAIL %s: valid=%0b pix=%h expected valid=%0b pix=%h",
                     tag, valid_o, pix_o, ev, ep);
        end
    endtask

    initial begin
        #4_000_000;
        errs++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [11:0] fw, sw, a1, b1, a2, b2;
        string tag;
        a1 = 12'h123; b1 = 12'h456; a2 = 12'h789; b2 = 12'hABC;

        // R1: reset state
        repeat (3) @(posedge clk);
        #2 chk("R1 in reset", 1'b0, 24'h0, 1'b1);
        rst_n = 1'b1;
        step(12'h0, 12'h0, 1'b0);
        chk("R1 after reset", 1'b0, 24'h0, 1'b1);

        // Table walk: R2 R3 R5 R6 plus restart blanking R8 R10
        for (int i = 0; i < 8; i++) begin
            fmt        = VEC[i][51:50];
            half_order = VEC[i][49];
            first_edge = VEC[i][48];
            fw = half_order ? VEC[i][35:24] : VEC[i][47:36];
            sw = half_order ? VEC[i][47:36] : VEC[i][35:24];
            tag = (fmt == 2'd0) ? (half_order ? "R3" : "R2") : ((fmt == 2'd1) ? "R5" : "R6");
            if (first_edge) begin
                step(fw, sw, 1'b1); chk("R8 align blank", 1'b0, 24'h0, 1'b0);
                step(fw, sw, 1'b0); chk("R10 first cycle", 1'b0, 24'h0, 1'b0);
                step(fw, sw, 1'b0); chk(tag, 1'b1, VEC[i][23:0], 1'b1);
            end else begin
                step(sw, fw, 1'b1); chk("R8 align blank", 1'b0, 24'h0, 1'b0);
                step(sw, fw, 1'b0); chk("R10 first cycle", 1'b0, 24'h0, 1'b0);
                step(sw, fw, 1'b0); chk(tag, 1'b1, VEC[i][23:0], 1'b1);
            end
        end

        // R9: format change without align, then R10 streaming
        fmt = 2'd1; half_order = 1'b0; first_edge = 1'b1;
        step(12'h0B3, 12'h069, 1'b0); chk("R9 fmt change blank", 1'b0, 24'h0, 1'b0);
        step(12'h0B3, 12'h069, 1'b0); chk("R9 second blank", 1'b0, 24'h0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            step(12'h0B3, 12'h069, 1'b0); chk("R10 stream", 1'b1, 24'hD66B9C, 1'b1);
        end

        // R4: edge pairing with distinct pixels, rising edge opens
        fmt = 2'd0; half_order = 1'b0; first_edge = 1'b0;
        step(12'h0, 12'h0, 1'b1);
        step(12'h0, a1, 1'b0);  chk("R4 e0 fill", 1'b0, 24'h0, 1'b0);
        step(b1, a2, 1'b0);     chk("R4 e0 pix1", 1'b1, 24'h456123, 1'b1);
        step(b2, 12'h0, 1'b0);  chk("R4 e0 pix2", 1'b1, 24'hABC789, 1'b1);

        // R4: falling edge opens
        first_edge = 1'b1;
        step(12'h0, 12'h0, 1'b1);
        step(a1, b1, 1'b0);     chk("R4 e1 fill", 1'b0, 24'h0, 1'b0);
        step(a2, b2, 1'b0);     chk("R4 e1 pix2", 1'b1, 24'hABC789, 1'b1);
        step(a1, b1, 1'b0);     chk("R4 e1 pix1", 1'b1, 24'h456123, 1'b1);

        // R7: 4:2:2 interleave, upper pins and edge/order bits ignored
        fmt = 2'd3; half_order = 1'b1; first_edge = 1'b0;
        step(12'h0, 12'h0, 1'b1);
        step(12'hF40, 12'hA11, 1'b0); chk("R7 fill", 1'b0, 24'h0, 1'b0);
        step(12'h9C0, 12'h522, 1'b0); chk("R7 pix0", 1'b1, 24'hC01140, 1'b1);
        step(12'h050, 12'hF33, 1'b0); chk("R7 pix1", 1'b1, 24'hC02240, 1'b1);
        step(12'h0D0, 12'h044, 1'b0); chk("R7 pix2", 1'b1, 24'hD03350, 1'b1);
        step(12'h060, 12'h055, 1'b1); chk("R8 422 align", 1'b0, 24'h0, 1'b0);
        step(12'h070, 12'h066, 1'b0); chk("R8 realign fill", 1'b0, 24'h0, 1'b0);
        step(12'h0E0, 12'h077, 1'b0); chk("R8 realign pix", 1'b1, 24'hE06670, 1'b1);
        step(12'h080, 12'h088, 1'b0); chk("R7 shared chroma", 1'b1, 24'hE07770, 1'b1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule